// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It reads a page directory entry and then a page table entry from memory, one word at a time, through a simple request/acknowledge memory port. A client hands over a linear address with three attributes: write, user mode and instruction fetch. The client holds the directory base and the write-protect enable steady for the length of a walk. Each walk ends in one of two ways. A one-cycle `done` strobe comes with the physical address. A one-cycle `fault` strobe comes with the faulting linear address and a three-bit error code.

Permission is a lookup in a 32-entry allow table. The table index combines the request attributes, the writable and user bits of both levels ANDed together, and the write-protect enable. A successful walk marks the entries it used as accessed. A successful write also marks the page entry dirty. Each changed entry is written back as one 32-bit store. A walk that faults stores nothing.

Top module: `pgwalk_top`

## Requirements
- R1: `req_ready` is high only while the walker is idle. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the cycle after the completion strobe.
- R2: The directory entry is read from `{dir_base[31:12], laddr[31:22], 2'b00}`, so the low 12 bits of `dir_base` are ignored. The table entry is read from `{pde[31:12], laddr[21:12], 2'b00}`.
- R3: A successful walk raises `done` and presents `paddr = {pte[31:12], laddr[11:0]}`.
- R4: If the present bit (bit 0) of the directory entry is clear, the walk faults without reading the table entry. If the present bit of the table entry is clear, the walk also faults. In both cases error-code bit 0 is 0.
- R5: The writable bits (bit 1) of the two entries are ANDed, and so are the user bits (bit 2). A user access needs combined user = 1. A user write also needs combined writable = 1. A supervisor write needs combined writable = 1 only when `wp_en` is 1. Supervisor reads are always allowed. A denied access faults with error-code bit 0 = 1.
- R6: On a fault, `fault_code` bit 1 holds the effective write flag and bit 2 holds the user flag. `fault_addr` takes the linear address and keeps it until the next fault.
- R7: After a permitted check, the accessed bit (bit 5) is set in the directory entry and then in the table entry. An entry is written back only if its word changes.
- R8: On a permitted write with the dirty bit (bit 6) clear, the table entry is stored once, with dirty and accessed both set. A read never sets dirty.
- R9: A walk that faults performs no memory write.
- R10: When `req_fetch` is 1 the access counts as a read: `req_write` has no effect on permission, dirty or the error code.
- R11: Only one memory access is outstanding at a time. `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until `mem_ack`.
- R12: `done` and `fault` are one-cycle strobes and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_base | input | 32 | Page directory base; bits 11:0 are ignored |
| wp_en | input | 1 | Supervisor write-protect enable |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_laddr | input | 32 | Linear address to translate |
| req_write | input | 1 | Request is a write |
| req_user | input | 1 | Request comes from user mode |
| req_fetch | input | 1 | Request is an instruction fetch (treated as a read) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory word address (byte address, 4-aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory access complete |
| done | output | 1 | One-cycle strobe: translation succeeded |
| paddr | output | 32 | Physical address of the last successful walk |
| fault | output | 1 | One-cycle strobe: page fault |
| fault_addr | output | 32 | Linear address of the last fault |
| fault_code | output | 3 | Error code: bit 0 protection, bit 1 write, bit 2 user |

## Verification
The walker keeps its state in the latched attributes, the two captured entries and the FSM state. A wrong bit in any of them shows up at the ports within the same walk. A mis-latched write or user flag shows as a wrong `fault_code` or a missing dirty update at the strobe. A stale entry shows as a wrong `paddr` or a wrong write-back word. An FSM that takes the wrong branch shows either as a memory store during a faulting walk or as a different count of port reads and writes before the strobe. Because every walk finishes within a few memory round trips, the bench compares each result, the table words in its memory model and the access counts right at the strobe. It does not wait for later traffic to reveal a fault.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_PDE,
    S_RD_PTE,
    S_CHECK,
    S_WR_PDE,
    S_WR_PTE,
    S_DONE,
    S_FAULT
  } walk_st_t;

  // Entry flag positions shared by both table levels
  localparam int BIT_P  = 0;
  localparam int BIT_RW = 1;
  localparam int BIT_US = 2;
  localparam int BIT_A  = 5;
  localparam int BIT_D  = 6;

  // Permission index layout: {wp, comb_user, comb_writable, user, write}
  localparam int PIDX_W = 5;

  function automatic logic [(1<<PIDX_W)-1:0] build_allow();
    logic [(1<<PIDX_W)-1:0] t;
    for (int i = 0; i < (1 << PIDX_W); i++) begin
      logic wr, us, pw, pu, wp;
      wr = i[0];
      us = i[1];
      pw = i[2];
      pu = i[3];
      wp = i[4];
      if (us) t[i] = pu & (~wr | pw);
      else    t[i] = ~wr | pw | ~wp;
    end
    return t;
  endfunction

endpackage

// File: rtl/pgwalk_perm.sv
module pgwalk_perm
  import pgwalk_pkg::*;
(
  input  logic is_write,
  input  logic is_user,
  input  logic comb_rw,
  input  logic comb_us,
  input  logic wp,
  output logic allow
);
  localparam logic [(1<<PIDX_W)-1:0] ALLOW_TBL = build_allow();

  logic [PIDX_W-1:0] idx;

  always_comb begin
    idx   = {wp, comb_us, comb_rw, is_user, is_write};
    allow = ALLOW_TBL[idx];
  end
endmodule

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 12
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] lin,
  input  logic [ADDR_W-1:0] dir_ent,
  input  logic [ADDR_W-1:0] tbl_ent,
  output logic [ADDR_W-1:0] dir_addr,
  output logic [ADDR_W-1:0] tbl_addr,
  output logic [ADDR_W-1:0] phys
);
  localparam int IDX_W = (ADDR_W - OFFS_W) / 2;
  localparam int ENT_B = OFFS_W - IDX_W;

  always_comb begin
    dir_addr = {base[ADDR_W-1:OFFS_W], lin[ADDR_W-1 -: IDX_W], {ENT_B{1'b0}}};
    tbl_addr = {dir_ent[ADDR_W-1:OFFS_W], lin[OFFS_W+IDX_W-1:OFFS_W], {ENT_B{1'b0}}};
    phys     = {tbl_ent[ADDR_W-1:OFFS_W], lin[OFFS_W-1:0]};
  end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 12,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] dir_base,
  input  logic              wp_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_laddr,
  input  logic              req_write,
  input  logic              req_user,
  input  logic              req_fetch,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] mem_wdata,
  input  logic [ADDR_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              done,
  output logic [ADDR_W-1:0] paddr,
  output logic              fault,
  output logic [ADDR_W-1:0] fault_addr,
  output logic [CODE_W-1:0] fault_code
);

  walk_st_t          st;
  logic [ADDR_W-1:0] laddr_q, base_q, pde_q, pte_q;
  logic              wr_q, usr_q, wp_q;

  logic [ADDR_W-1:0] lin_sel, base_sel;
  logic [ADDR_W-1:0] dir_addr, tbl_addr, phys;
  logic              allow;
  logic              pte_upd;
  logic [ADDR_W-1:0] pte_new;

  always_comb begin
    lin_sel  = (st == S_IDLE) ? req_laddr : laddr_q;
    base_sel = (st == S_IDLE) ? dir_base  : base_q;
    pte_upd  = ~pte_q[BIT_A] | (wr_q & ~pte_q[BIT_D]);
    pte_new  = pte_q;
    pte_new[BIT_A] = 1'b1;
    if (wr_q) pte_new[BIT_D] = 1'b1;
  end

  pgwalk_addr #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_addr (
    .base    (base_sel),
    .lin     (lin_sel),
    .dir_ent (mem_rdata),
    .tbl_ent (pte_q),
    .dir_addr(dir_addr),
    .tbl_addr(tbl_addr),
    .phys    (phys)
  );

  pgwalk_perm u_perm (
    .is_write(wr_q),
    .is_user (usr_q),
    .comb_rw (pde_q[BIT_RW] & pte_q[BIT_RW]),
    .comb_us (pde_q[BIT_US] & pte_q[BIT_US]),
    .wp      (wp_q),
    .allow   (allow)
  );

  assign req_ready = (st == S_IDLE);
  assign done      = (st == S_DONE);
  assign fault     = (st == S_FAULT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      laddr_q    <= '0;
      base_q     <= '0;
      pde_q      <= '0;
      pte_q      <= '0;
      wr_q       <= 1'b0;
      usr_q      <= 1'b0;
      wp_q       <= 1'b0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      paddr      <= '0;
      fault_addr <= '0;
      fault_code <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            laddr_q  <= req_laddr;
            base_q   <= dir_base;
            wr_q     <= req_write & ~req_fetch;
            usr_q    <= req_user;
            wp_q     <= wp_en;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= dir_addr;
            st       <= S_RD_PDE;
          end
        end
        S_RD_PDE: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            pde_q   <= mem_rdata;
            if (!mem_rdata[BIT_P]) begin
              fault_addr <= laddr_q;
              fault_code <= {usr_q, wr_q, 1'b0};
              st         <= S_FAULT;
            end else begin
              mem_req  <= 1'b1;
              mem_addr <= tbl_addr;
              st       <= S_RD_PTE;
            end
          end
        end
        S_RD_PTE: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            pte_q   <= mem_rdata;
            if (!mem_rdata[BIT_P]) begin
              fault_addr <= laddr_q;
              fault_code <= {usr_q, wr_q, 1'b0};
              st         <= S_FAULT;
            end else begin
              st <= S_CHECK;
            end
          end
        end
        S_CHECK: begin
          if (!allow) begin
            fault_addr <= laddr_q;
            fault_code <= {usr_q, wr_q, 1'b1};
            st         <= S_FAULT;
          end else if (!pde_q[BIT_A]) begin
            mem_req          <= 1'b1;
            mem_we           <= 1'b1;
            mem_addr         <= dir_addr;
            mem_wdata        <= pde_q | (ADDR_W'(1) << BIT_A);
            pde_q[BIT_A]     <= 1'b1;
            st               <= S_WR_PDE;
          end else if (pte_upd) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= {pde_q[ADDR_W-1:OFFS_W], {OFFS_W{1'b0}}} | (tbl_addr & ADDR_W'((1 << OFFS_W) - 1));
            mem_wdata <= pte_new;
            st        <= S_WR_PTE;
          end else begin
            paddr <= phys;
            st    <= S_DONE;
          end
        end
        S_WR_PDE: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            if (pte_upd) begin
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= {pde_q[ADDR_W-1:OFFS_W], {OFFS_W{1'b0}}} | (tbl_addr & ADDR_W'((1 << OFFS_W) - 1));
              mem_wdata <= pte_new;
              st        <= S_WR_PTE;
            end else begin
              paddr <= phys;
              st    <= S_DONE;
            end
          end
        end
        S_WR_PTE: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            pte_q   <= pte_new;
            paddr   <= phys;
            st      <= S_DONE;
          end
        end
        S_DONE:  st <= S_IDLE;
        S_FAULT: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && fault));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R12
  fault_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fault |=> !fault);

  // R1
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R9
  fault_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_req) |-> !fault);

  // R4
  dir_np_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_RD_PDE && mem_ack && !mem_rdata[BIT_P]) |=> (fault && !fault_code[0]));

  // R5
  user_perm_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_CHECK && usr_q && !(pde_q[BIT_US] && pte_q[BIT_US])) |=> (fault && fault_code[0]));

endmodule

// File: tb/sim_pgwalk_top.sv
module sim_pgwalk_top;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 4096;
  localparam int WDOG_LIM   = 20000;

  localparam logic [31:0] FP = 32'h01;
  localparam logic [31:0] FW = 32'h02;
  localparam logic [31:0] FU = 32'h04;
  localparam logic [31:0] FA = 32'h20;
  localparam logic [31:0] FD = 32'h40;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] dir_base;
  logic        wp_en;
  logic        req_valid, req_ready;
  logic [31:0] req_laddr;
  logic        req_write, req_user, req_fetch;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_ack;
  logic        done, fault;
  logic [31:0] paddr, fault_addr;
  logic [2:0]  fault_code;

  logic [31:0] mem [0:MEM_WORDS-1];
  int rd_cnt, wr_cnt;
  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgwalk_top u0 (
    .clk(clk), .rst(rst), .dir_base(dir_base), .wp_en(wp_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
    .req_write(req_write), .req_user(req_user), .req_fetch(req_fetch),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .done(done), .paddr(paddr), .fault(fault),
    .fault_addr(fault_addr), .fault_code(fault_code)
  );

  // memory model: serves one access per two negedges
  initial begin
    mem_ack   = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        mem_ack = 1'b1;
        if (mem_we) begin
          mem[mem_addr[13:2]] = mem_wdata;
          wr_cnt++;
        end else begin
          mem_rdata = mem[mem_addr[13:2]];
          rd_cnt++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // issue one request and wait for its strobe; leaves time at the strobe negedge
  task automatic run(input logic [31:0] la, input logic wr, input logic us, input logic fe);
    @(negedge clk);
    rd_cnt = 0;
    wr_cnt = 0;
    req_laddr = la; req_write = wr; req_user = us; req_fetch = fe;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1 ready low during walk", 32'(req_ready), 32'h0);
    for (int i = 0; i < 200; i++) begin
      if (done || fault) break;
      @(negedge clk);
    end
  endtask

  task automatic finish_walk();
    @(negedge clk);
    chk(req_ready == 1'b1 && !done && !fault, "R1/R12 back to idle", {req_ready, done, fault}, 32'h4);
  endtask

  // laddr 0x0040_3abc: directory index 1, table index 3
  localparam logic [31:0] LA = 32'h0040_3abc;
  localparam int PDE_W = 1;
  localparam int PTE_W = 1024 + 3;

  task automatic t_reset();
    chk(req_ready && !done && !fault && !mem_req, "R1 reset state",
        {28'h0, req_ready, done, fault, mem_req}, 32'h8);
  endtask

  task automatic t_read_fresh();
    mem[PDE_W] = 32'h0000_1000 | FP | FW | FU;
    mem[PTE_W] = 32'h1234_5000 | FP | FW | FU;
    wp_en = 1'b0;
    run(LA, 1'b0, 1'b0, 1'b0);
    chk(done, "R3 read done", 32'(done), 32'h1);
    chk(paddr == 32'h1234_5abc, "R3 paddr", paddr, 32'h1234_5abc);
    chk(mem[PDE_W] == (32'h0000_1000 | FP | FW | FU | FA), "R7 pde accessed", mem[PDE_W], 32'h0000_1027);
    chk(mem[PTE_W] == (32'h1234_5000 | FP | FW | FU | FA), "R8 read keeps dirty clear", mem[PTE_W], 32'h1234_5027);
    chk(rd_cnt == 2 && wr_cnt == 2, "R11 access count fresh read", 32'(rd_cnt*16 + wr_cnt), 32'h22);
    finish_walk();
  endtask

  task automatic t_write_clean();
    mem[PDE_W] = 32'h0000_1000 | FP | FW | FA;
    mem[PTE_W] = 32'h0abc_d000 | FP | FW;
    run(LA, 1'b1, 1'b0, 1'b0);
    chk(done && paddr == 32'h0abc_dabc, "R3 write paddr", paddr, 32'h0abc_dabc);
    chk(mem[PTE_W] == (32'h0abc_d000 | FP | FW | FA | FD), "R8 dirty+accessed", mem[PTE_W], 32'h0abc_d063);
    chk(wr_cnt == 1, "R8 single store", 32'(wr_cnt), 32'h1);
    finish_walk();
  endtask

  task automatic t_no_change();
    mem[PDE_W] = 32'h0000_1000 | FP | FW | FA;
    mem[PTE_W] = 32'h0555_5000 | FP | FW | FA | FD;
    run(LA, 1'b1, 1'b0, 1'b0);
    chk(done && rd_cnt == 2 && wr_cnt == 0, "R7 no write-back when unchanged",
        32'(rd_cnt*16 + wr_cnt), 32'h20);
    finish_walk();
  endtask

  task automatic t_pde_np();
    mem[PDE_W] = 32'h0000_1000 | FW | FU;
    mem[PTE_W] = 32'h1111_1000 | FP | FW | FU;
    run(LA, 1'b1, 1'b1, 1'b0);
    chk(fault && fault_code == 3'b110, "R4 dir not present code", 32'(fault_code), 32'h6);
    chk(fault_addr == LA, "R6 fault addr", fault_addr, LA);
    chk(rd_cnt == 1 && wr_cnt == 0, "R9 dir np: one read no write", 32'(rd_cnt*16 + wr_cnt), 32'h10);
    finish_walk();
  endtask

  task automatic t_pte_np();
    mem[PDE_W] = 32'h0000_1000 | FP | FW | FU;
    mem[PTE_W] = 32'h1111_1000 | FW | FU;
    run(32'h0040_3004, 1'b0, 1'b0, 1'b0);
    chk(fault && fault_code == 3'b000, "R4 table not present code", 32'(fault_code), 32'h0);
    chk(wr_cnt == 0 && mem[PDE_W] == (32'h0000_1000 | FP | FW | FU), "R9 pde untouched", mem[PDE_W], 32'h0000_1007);
    finish_walk();
  endtask

  task automatic t_user_super();
    mem[PDE_W] = 32'h0000_1000 | FP | FW | FU;
    mem[PTE_W] = 32'h2222_2000 | FP | FW;
    run(LA, 1'b0, 1'b1, 1'b0);
    chk(fault && fault_code == 3'b101, "R5 user read of supervisor page", 32'(fault_code), 32'h5);
    chk(wr_cnt == 0 && mem[PTE_W] == (32'h2222_2000 | FP | FW), "R9 no accessed on fault", mem[PTE_W], 32'h2222_2003);
    finish_walk();
  endtask

  task automatic t_wp();
    mem[PDE_W] = 32'h0000_1000 | FP | FW | FA;
    mem[PTE_W] = 32'h3333_3000 | FP | FA | FD;
    wp_en = 1'b0;
    run(LA, 1'b1, 1'b0, 1'b0);
    chk(done && paddr == 32'h3333_3abc, "R5 supervisor write ro wp=0", paddr, 32'h3333_3abc);
    finish_walk();
    wp_en = 1'b1;
    run(LA, 1'b1, 1'b0, 1'b0);
    chk(fault && fault_code == 3'b011, "R5 supervisor write ro wp=1", 32'(fault_code), 32'h3);
    finish_walk();
    wp_en = 1'b0;
  endtask

  task automatic t_user_and();
    mem[PDE_W] = 32'h0000_1000 | FP | FU | FA;
    mem[PTE_W] = 32'h4444_4000 | FP | FW | FU | FA;
    run(32'h0040_3ffc, 1'b1, 1'b1, 1'b0);
    chk(fault && fault_code == 3'b111, "R5 combined writable ANDed", 32'(fault_code), 32'h7);
    chk(fault_addr == 32'h0040_3ffc, "R6 fault addr second", fault_addr, 32'h0040_3ffc);
    finish_walk();
    mem[PDE_W] = 32'h0000_1000 | FP | FW | FU | FA;
    run(32'h0040_3ffc, 1'b1, 1'b1, 1'b0);
    chk(done && paddr == 32'h4444_4ffc, "R5 user write allowed", paddr, 32'h4444_4ffc);
    chk(fault_addr == 32'h0040_3ffc, "R6 fault addr held after success", fault_addr, 32'h0040_3ffc);
    finish_walk();
  endtask

  task automatic t_fetch();
    mem[PDE_W] = 32'h0000_1000 | FP | FA;
    mem[PTE_W] = 32'h5555_5000 | FP | FA;
    wp_en = 1'b1;
    run(LA, 1'b1, 1'b0, 1'b1);
    chk(done && wr_cnt == 0, "R10 fetch ignores write", 32'(wr_cnt), 32'h0);
    chk(mem[PTE_W] == (32'h5555_5000 | FP | FA), "R10 fetch no dirty", mem[PTE_W], 32'h5555_5021);
    finish_walk();
    mem[PTE_W] = 32'h5555_5000;
    run(LA, 1'b1, 1'b1, 1'b1);
    chk(fault && fault_code == 3'b100, "R10 fetch error code write clear", 32'(fault_code), 32'h4);
    finish_walk();
    wp_en = 1'b0;
  endtask

  task automatic t_base();
    // base 0x3123 (low bits ignored), directory index 5
    dir_base = 32'h0000_3123;
    mem[(32'h3000 >> 2) + 5] = 32'h0000_2000 | FP | FW | FA;
    mem[(32'h2000 >> 2) + 7] = 32'h6666_6000 | FP | FW | FA;
    run(32'h0140_7123, 1'b0, 1'b0, 1'b0);
    chk(done && paddr == 32'h6666_6123, "R2 entry addressing", paddr, 32'h6666_6123);
    finish_walk();
    dir_base = 32'h0;
  endtask

  initial begin
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = '0;
    rst = 1'b1;
    dir_base = '0; wp_en = 1'b0;
    req_valid = 1'b0; req_laddr = '0; req_write = 1'b0; req_user = 1'b0; req_fetch = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read_fresh();
    t_write_clean();
    t_no_change();
    t_pde_np();
    t_pte_np();
    t_user_super();
    t_wp();
    t_user_and();
    t_fetch();
    t_base();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < WDOG_LIM; c++) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", WDOG_LIM, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule